// File: doc/BRIEF.md
# Nibble Arithmetic and Logic Unit with Decimal Adjust

This block is the combinational datapath of a small accumulator machine that works on 4-bit words. Each cycle the sequencer presents the accumulator value, a second operand (read from data memory or taken from an immediate field), the current carry flag and an operation code. Within the same cycle the unit returns the new accumulator value, the new carry value, and a write-enable. The write-enable tells the sequencer whether to load the carry flag.

There is no state and no clock inside. The unit has no state machine. The operation code plays the role of a state selector: every code picks one datapath (the carry chain, the decimal corrector, the bitwise/step unit or the rotator) through a unique case. Subtraction is built as addition of the inverted operand, so the carry out means "no borrow". Decimal adjust can set the carry but never clear it. Increment, decrement and the bitwise operations leave the carry alone.

Operation codes (`op_i`): 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 decimal adjust, 5 AND, 6 OR, 7 XOR, 8 rotate left, 9 rotate right, 10 rotate left through carry, 11 rotate right through carry, 12 increment, 13 decrement, 14 and 15 reserved.

Top module: `alu4_bcd`

## Requirements
- R1: With op 0, res_o = (acc_i + opnd_i) mod 16 and cy_o is the fifth bit of that sum. With op 1 the same holds for acc_i + opnd_i + cy_i. cy_we_o is 1 for both.
- R2: With op 2, res_o = (acc_i - opnd_i) mod 16, which is the low nibble of acc_i + ~opnd_i + 1. cy_o is 1 when acc_i >= opnd_i (no borrow) and 0 otherwise. cy_we_o is 1.
- R3: With op 3, res_o is the low nibble of acc_i + ~opnd_i + cy_i, and cy_o is its fifth bit. cy_we_o is 1.
- R4: With op 4, when acc_i > 9 or cy_i = 1, res_o = (acc_i + 6) mod 16 and cy_o = 1. Otherwise res_o = acc_i and cy_o = cy_i. cy_we_o is 1.
- R5: With op 8, res_o = {acc_i[2:0], acc_i[3]} and cy_o = acc_i[3]. With op 9, res_o = {acc_i[0], acc_i[3:1]} and cy_o = acc_i[0]. cy_we_o is 1.
- R6: With op 10, res_o = {acc_i[2:0], cy_i} and cy_o = acc_i[3]. With op 11, res_o = {cy_i, acc_i[3:1]} and cy_o = acc_i[0]. cy_we_o is 1.
- R7: With op 12 res_o = (acc_i + 1) mod 16, and with op 13 res_o = (acc_i - 1) mod 16. cy_o = cy_i and cy_we_o = 0.
- R8: Ops 5, 6 and 7 give the bitwise AND, OR and XOR of acc_i and opnd_i, with cy_o = cy_i and cy_we_o = 0.
- R9: cy_we_o is 1 exactly for ops 0 to 4 and 8 to 11.
- R10: Reserved ops 14 and 15 give res_o = acc_i, cy_o = cy_i and cy_we_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 4 | Accumulator value |
| opnd_i | input | 4 | Second operand (memory or immediate) |
| cy_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| res_o | output | 4 | Result for the accumulator |
| cy_o | output | 1 | New carry value |
| cy_we_o | output | 1 | Carry flag load enable |

## Verification
The bench targets these corner cases:
- Subtraction where the operands are equal. A design that treated the carry as a borrow flag would clear the carry here instead of setting it.
- Subtract with borrow with the carry both set and clear. This catches a carry-in that is inverted or ignored.
- Decimal adjust on 9 and on 10, and on small values with the carry set. A unit that cleared the carry or skipped the correction when the carry is set fails on these.
- Rotates through the carry on patterns whose end bits differ from the carry. A swapped bit 0 and bit 3 shows up there.
- Increment of 15 and decrement of 0, each with the carry set. A wrong wrap or a clobbered carry shows up there.

Random operands over every code, including the reserved ones, cover the rest.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_DAA  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_RL   = 4'd8,
        OP_RR   = 4'd9,
        OP_RLC  = 4'd10,
        OP_RRC  = 4'd11,
        OP_INC  = 4'd12,
        OP_DEC  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    // Datapath groups selected by an operation code
    typedef enum logic [1:0] {
        GRP_ARITH = 2'd0,
        GRP_BITS  = 2'd1,
        GRP_ROT   = 2'd2,
        GRP_PASS  = 2'd3
    } alu_grp_e;

    function automatic alu_grp_e grp_of(alu_op_e op);
        alu_grp_e g;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_DAA: g = GRP_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:  g = GRP_BITS;
            OP_RL, OP_RR, OP_RLC, OP_RRC:           g = GRP_ROT;
            default:                                g = GRP_PASS;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/alu4_arith.sv
module alu4_arith
    import alu4_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   m,
    input  logic           ci,
    output logic [W-1:0]   res,
    output logic           co
);
    localparam int          DEC_LIMIT = 9;
    localparam int          DEC_CORR  = (1 << W) - 10;
    localparam logic [W-1:0] LIMIT_V  = DEC_LIMIT[W-1:0];
    localparam logic [W-1:0] CORR_V   = DEC_CORR[W-1:0];

    logic           inv_m;
    logic           chain_cin;
    logic [W-1:0]   mb;
    logic [W:0]     ch;
    logic [W-1:0]   sum;
    logic           need_adj;
    logic [W-1:0]   adj_val;

    always_comb begin
        unique case (op)
            OP_ADD:  begin inv_m = 1'b0; chain_cin = 1'b0; end
            OP_ADC:  begin inv_m = 1'b0; chain_cin = ci;   end
            OP_SUB:  begin inv_m = 1'b1; chain_cin = 1'b1; end
            OP_SBC:  begin inv_m = 1'b1; chain_cin = ci;   end
            default: begin inv_m = 1'b0; chain_cin = 1'b0; end
        endcase
    end

    assign mb    = inv_m ? ~m : m;
    assign ch[0] = chain_cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]  = a[i] ^ mb[i] ^ ch[i];
        assign ch[i+1] = (a[i] & mb[i]) | (ch[i] & (a[i] ^ mb[i]));
    end

    assign need_adj = (a > LIMIT_V) | ci;
    assign adj_val  = a + CORR_V;

    always_comb begin
        if (op == OP_DAA) begin
            res = need_adj ? adj_val : a;
            co  = need_adj ? 1'b1 : ci;
        end else begin
            res = sum;
            co  = ch[W];
        end
    end

    always_comb begin
        if (!$isunknown({op, a, m, ci})) begin
            // R1
            add_sum_chk: assert (op != OP_ADD || {co, res} == ({1'b0, a} + {1'b0, m}))
                else $error("add_sum_chk");
            // R2
            sub_noborrow_chk: assert (op != OP_SUB || co == (a >= m))
                else $error("sub_noborrow_chk");
        end
    end

endmodule

// File: rtl/alu4_bits.sv
module alu4_bits
    import alu4_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   res
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (op)
            OP_AND:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            OP_INC:  res = a + ONE;
            OP_DEC:  res = a - ONE;
            default: res = a;
        endcase
    end

    always_comb begin
        if (!$isunknown({op, a})) begin
            // R7
            step_wrap_chk: assert (!(op == OP_INC && a == '1) || res == '0)
                else $error("step_wrap_chk");
        end
    end

endmodule

// File: rtl/alu4_rot.sv
module alu4_rot
    import alu4_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           ci,
    output logic [W-1:0]   res,
    output logic           co
);
    logic fill_lo;
    logic fill_hi;

    always_comb begin
        fill_lo = (op == OP_RLC) ? ci : a[W-1];
        fill_hi = (op == OP_RRC) ? ci : a[0];
        unique case (op)
            OP_RL, OP_RLC: begin res = {a[W-2:0], fill_lo}; co = a[W-1]; end
            OP_RR, OP_RRC: begin res = {fill_hi, a[W-1:1]}; co = a[0];   end
            default:       begin res = a;                   co = ci;     end
        endcase
    end

    always_comb begin
        if (!$isunknown({op, a, ci})) begin
            // R5
            rol_wrap_chk: assert (op != OP_RL || (res[0] == a[W-1] && co == a[W-1]))
                else $error("rol_wrap_chk");
            // R6
            rrc_fill_chk: assert (op != OP_RRC || (res[W-1] == ci && co == a[0]))
                else $error("rrc_fill_chk");
        end
    end

endmodule

// File: rtl/alu4_bcd.sv
module alu4_bcd
    import alu4_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]    acc_i,
    input  logic [W-1:0]    opnd_i,
    input  logic            cy_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    res_o,
    output logic            cy_o,
    output logic            cy_we_o
);
    alu_op_e      op;
    alu_grp_e     grp;
    logic [W-1:0] ar_res;
    logic         ar_co;
    logic [W-1:0] bt_res;
    logic [W-1:0] rt_res;
    logic         rt_co;

    assign op  = alu_op_e'(op_i);
    assign grp = grp_of(op);

    alu4_arith #(.W(W)) u_arith (
        .op  (op),
        .a   (acc_i),
        .m   (opnd_i),
        .ci  (cy_i),
        .res (ar_res),
        .co  (ar_co)
    );

    alu4_bits #(.W(W)) u_bits (
        .op  (op),
        .a   (acc_i),
        .m   (opnd_i),
        .res (bt_res)
    );

    alu4_rot #(.W(W)) u_rot (
        .op  (op),
        .a   (acc_i),
        .ci  (cy_i),
        .res (rt_res),
        .co  (rt_co)
    );

    always_comb begin
        unique case (grp)
            GRP_ARITH: begin res_o = ar_res; cy_o = ar_co; cy_we_o = 1'b1; end
            GRP_BITS:  begin res_o = bt_res; cy_o = cy_i;  cy_we_o = 1'b0; end
            GRP_ROT:   begin res_o = rt_res; cy_o = rt_co; cy_we_o = 1'b1; end
            default:   begin res_o = acc_i;  cy_o = cy_i;  cy_we_o = 1'b0; end
        endcase
    end

    always_comb begin
        if (!$isunknown({op_i, acc_i, opnd_i, cy_i})) begin
            // R4
            daa_set_only_chk: assert (op != OP_DAA || (cy_we_o && (cy_o || !cy_i)))
                else $error("daa_set_only_chk");
            // R8
            bits_keep_cy_chk: assert (!(op inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC})
                                      || (!cy_we_o && cy_o == cy_i))
                else $error("bits_keep_cy_chk");
            // R10
            rsv_pass_chk: assert (!(op inside {OP_RSV0, OP_RSV1})
                                  || (res_o == acc_i && cy_o == cy_i && !cy_we_o))
                else $error("rsv_pass_chk");
            // R9
            we_no_write_keeps_cy_chk: assert (cy_we_o || cy_o == cy_i)
                else $error("we_no_write_keeps_cy_chk");
        end
    end

endmodule

// File: tb/alu4_bcd_tb.sv
module alu4_bcd_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] acc, opnd, op;
    logic       cy;
    logic [3:0] res;
    logic       cyo, we;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    alu4_bcd u_dut (
        .acc_i   (acc),
        .opnd_i  (opnd),
        .cy_i    (cy),
        .op_i    (op),
        .res_o   (res),
        .cy_o    (cyo),
        .cy_we_o (we)
    );

    function automatic string req_of(int o);
        case (o)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            8, 9:    return "R5";
            10, 11:  return "R6";
            12, 13:  return "R7";
            5, 6, 7: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Expected {we, cy, res} from the requirement text
    function automatic logic [5:0] model(int o, int a, int m, int c);
        int s;
        int r;
        int k;
        int w;
        k = c; w = 0; r = a;
        case (o)
            0:  begin s = a + m;            r = s % 16; k = s / 16; w = 1; end
            1:  begin s = a + m + c;        r = s % 16; k = s / 16; w = 1; end
            2:  begin r = (a - m + 16) % 16; k = (a >= m) ? 1 : 0;   w = 1; end
            3:  begin s = a + (15 - m) + c; r = s % 16; k = s / 16; w = 1; end
            4:  begin
                    w = 1;
                    if (a > 9 || c == 1) begin r = (a + 6) % 16; k = 1; end
                end
            5:  r = a & m;
            6:  r = a | m;
            7:  r = a ^ m;
            8:  begin r = ((a * 2) % 16) + a / 8;      k = a / 8;     w = 1; end
            9:  begin r = a / 2 + (a % 2) * 8;          k = a % 2;     w = 1; end
            10: begin r = ((a * 2) % 16) + c;           k = a / 8;     w = 1; end
            11: begin r = a / 2 + c * 8;                k = a % 2;     w = 1; end
            12: r = (a + 1) % 16;
            13: r = (a + 15) % 16;
            default: ;
        endcase
        return {w[0], k[0], r[3:0]};
    endfunction

    task automatic check(string tag);
        logic [5:0] e;
        e = model(int'(op), int'(acc), int'(opnd), int'(cy));
        checks++;
        if ({we, cyo, res} !== e) begin
            errors++;
            $display("FAIL %s op=%0d acc=%0d opnd=%0d cy=%0d actual we=%0b cy=%0b res=%0d expected we=%0b cy=%0b res=%0d",
                     tag, op, acc, opnd, cy, we, cyo, res, e[5], e[4], e[3:0]);
        end
    endtask

    task automatic apply(int o, int a, int m, int c);
        @(negedge clk);
        op = 4'(o); acc = 4'(a); opnd = 4'(m); cy = c[0];
        #2;
        check(req_of(o));
    endtask

    initial begin
        op = 4'd0; acc = 4'd0; opnd = 4'd0; cy = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs after reset: add of zeros (R1)
        apply(0, 0, 0, 0);
        // R1 carry out of add and add with carry
        apply(0, 15, 1, 0);
        apply(1, 15, 0, 1);
        apply(1, 7, 8, 1);
        // R2 equal operands: no borrow, carry set
        apply(2, 5, 5, 0);
        apply(2, 3, 4, 1);
        // R3 borrow-in both ways
        apply(3, 5, 5, 0);
        apply(3, 5, 5, 1);
        apply(3, 0, 15, 1);
        // R4 decimal adjust edges
        apply(4, 9, 0, 0);
        apply(4, 10, 0, 0);
        apply(4, 3, 0, 1);
        apply(4, 15, 0, 0);
        // R5 and R6 rotates with end bits differing from carry
        apply(8, 8, 0, 0);
        apply(9, 1, 0, 0);
        apply(10, 6, 0, 1);
        apply(11, 6, 0, 1);
        apply(10, 9, 0, 0);
        // R7 wraps with carry held
        apply(12, 15, 0, 1);
        apply(13, 0, 0, 1);
        // R8 bitwise with carry set, R10 reserved codes, R9 covered by we field
        apply(5, 12, 10, 1);
        apply(6, 12, 10, 0);
        apply(7, 12, 10, 1);
        apply(14, 11, 3, 1);
        apply(15, 4, 9, 0);
        // Random sweep over all codes
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            apply(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16), int'($urandom % 2));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule